// File: doc/BRIEF.md
# Programming Lock Byte Controller

This block keeps the 8-bit lock byte that decides what an external programmer may do to the device. A serial or parallel programming front end presents one request per cycle: write the lock byte, write fuses, program memory, verify memory, or erase the whole chip. The block answers each request with a one-cycle grant or deny pulse and updates its own stored lock value when a lock write or chip erase is granted.

A lock bit reads 1 when it is unprogrammed and 0 when it is programmed. Programming can only clear bits. Only a chip erase sets them back to 1. The two low bits select a memory-lock level. That level gates memory programming, verification and fuse writes. At the strictest level it also freezes the boot-lock fields. The decoded level and the two boot-lock pairs are driven out to neighbouring logic. The stored byte is a register whose reset value models the power-on default.

A small state machine holds the response for the cycle after each request. It has four states:
- `RSP_IDLE`: no pulse.
- `RSP_GRANT`: grant pulse.
- `RSP_DENY`: deny pulse.
- `RSP_ERASED`: grant and erase-done pulse.

Any state moves to:
- `RSP_ERASED` on a chip-erase request.
- `RSP_GRANT` on a permitted request.
- `RSP_DENY` on a refused request.
- `RSP_IDLE` when no request is present.

Top module: `lockbyte_ctrl`

## Requirements
- R1: After reset the lock byte is 8'hFF, `mem_mode` is 0, and neither `grant` nor `deny` is asserted.
- R2: Field positions are fixed. The level bits are lock[1:0]. `app_lock` is lock[3:2]. `boot_lock` is lock[5:4]. Bits 7:6 are spare.
- R3: A granted lock write (`req_kind` 0) stores old AND `req_data`. A data bit of 1 never turns a stored 0 back into 1.
- R4: `mem_mode` decodes lock[1:0] as follows: 2'b11 gives 0 (open), 2'b10 gives 1 (no-program), and both 2'b00 and 2'b01 give 2 (sealed).
- R5: In open mode, every defined request is granted: 0 lock write, 1 fuse write, 2 memory program, 3 memory verify.
- R6: In no-program mode, memory program and fuse write are denied, while memory verify and lock write are granted.
- R7: In sealed mode, memory program, verify and fuse write are denied. A lock write is granted, but it leaves lock[5:2] unchanged while still clearing lock[7:6] and lock[1:0].
- R8: Chip erase (`req_kind` 4) is granted in every mode. In the cycle it is answered, the lock byte is 8'hFF and `erase_done` pulses together with `grant`.
- R9: Each sampled request gives exactly one of `grant` or `deny`, for one cycle, in the cycle after it is sampled. A cycle with no request gives neither in the following cycle.
- R10: The `req_path` input (0 serial, 1 parallel) has no effect on any outcome.
- R11: Request kinds 5 to 7 are denied and leave the lock byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 3 | Request code: 0 lock write, 1 fuse write, 2 memory program, 3 memory verify, 4 chip erase |
| req_path | input | 1 | Front end used: 0 serial, 1 parallel (outcome-neutral) |
| req_data | input | 8 | Value requested for a lock write |
| grant | output | 1 | Request permitted (one-cycle pulse) |
| deny | output | 1 | Request refused (one-cycle pulse) |
| erase_done | output | 1 | Chip erase completed (one-cycle pulse) |
| lock_q | output | 8 | Stored lock byte |
| mem_mode | output | 2 | Decoded memory-lock level: 0 open, 1 no-program, 2 sealed |
| app_lock | output | 2 | Application-section boot-lock pair, lock[3:2] |
| boot_lock | output | 2 | Boot-section boot-lock pair, lock[5:4] |

## Verification
The bound checker watches several properties on every cycle:
- `grant` and `deny` are never asserted together.
- Without an erase, no lock bit ever rises from 0 to 1.
- An erase always yields 8'hFF together with `grant` and `erase_done`.
- The sealed level freezes lock[5:2].
- Memory program in sealed mode is always refused.
- Verify in no-program mode is always granted.
- An idle cycle produces no response.

The directed scenarios cover what needs a chosen history. They check the exact AND arithmetic of lock writes and the treatment of the undefined 2'b01 level code. They also check that serial and parallel requests behave the same, that unknown request codes are rejected, and that the exposed fields sit at their stated positions.

// File: rtl/lockbyte_pkg.sv
package lockbyte_pkg;
    localparam int LOCK_W      = 8;
    localparam int LVL_LSB     = 0;
    localparam int APP_LSB     = 2;
    localparam int BOOT_LSB    = 4;
    localparam int BOOTF_MSB   = 5;
    localparam logic [LOCK_W-1:0] LOCK_BLANK = '1;
    // Mask of the boot-lock fields frozen by the sealed level.
    localparam logic [LOCK_W-1:0] BOOTF_MASK =
        LOCK_W'(((1 << (BOOTF_MSB - APP_LSB + 1)) - 1) << APP_LSB);

    typedef enum logic [2:0] {
        KIND_LOCK_WR = 3'd0,
        KIND_FUSE_WR = 3'd1,
        KIND_MEM_PRG = 3'd2,
        KIND_MEM_VFY = 3'd3,
        KIND_ERASE   = 3'd4
    } req_kind_e;

    typedef enum logic [1:0] {
        MODE_OPEN   = 2'd0,
        MODE_NOPROG = 2'd1,
        MODE_SEALED = 2'd2
    } lock_mode_e;

    typedef enum logic [1:0] {
        RSP_IDLE   = 2'd0,
        RSP_GRANT  = 2'd1,
        RSP_DENY   = 2'd2,
        RSP_ERASED = 2'd3
    } rsp_state_e;
endpackage

// File: rtl/lockbyte_decode.sv
module lockbyte_decode
    import lockbyte_pkg::*;
(
    input  logic [1:0] lvl_bits,
    output lock_mode_e mode
);
    always_comb begin
        unique case (lvl_bits)
            2'b11:   mode = MODE_OPEN;
            2'b10:   mode = MODE_NOPROG;
            default: mode = MODE_SEALED;   // 2'b00 and the undefined 2'b01
        endcase
    end
endmodule

// File: rtl/lockbyte_policy.sv
module lockbyte_policy
    import lockbyte_pkg::*;
(
    input  lock_mode_e        mode,
    input  logic [2:0]        kind,
    input  logic [LOCK_W-1:0] cur,
    input  logic [LOCK_W-1:0] data,
    output logic              allow,
    output logic              do_erase,
    output logic              do_write,
    output logic [LOCK_W-1:0] new_val
);
    logic [LOCK_W-1:0] keep_mask;

    always_comb begin
        keep_mask = (mode == MODE_SEALED) ? BOOTF_MASK : '0;
        // Programming only clears; frozen fields keep their stored value.
        new_val   = (cur & data) | (cur & keep_mask);
        allow     = 1'b0;
        do_erase  = 1'b0;
        do_write  = 1'b0;
        case (kind)
            KIND_LOCK_WR: begin
                allow    = 1'b1;
                do_write = 1'b1;
            end
            KIND_FUSE_WR: allow = (mode == MODE_OPEN);
            KIND_MEM_PRG: allow = (mode == MODE_OPEN);
            KIND_MEM_VFY: allow = (mode != MODE_SEALED);
            KIND_ERASE: begin
                allow    = 1'b1;
                do_erase = 1'b1;
            end
            default: allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/lockbyte_store.sv
module lockbyte_store
    import lockbyte_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [LOCK_W-1:0] wr_val,
    output logic [LOCK_W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      value <= LOCK_BLANK;
        else if (erase)  value <= LOCK_BLANK;
        else if (wr_en)  value <= wr_val;
    end
endmodule

// File: rtl/lockbyte_ctrl.sv
module lockbyte_ctrl
    import lockbyte_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic              req_path,
    input  logic [LOCK_W-1:0] req_data,
    output logic              grant,
    output logic              deny,
    output logic              erase_done,
    output logic [LOCK_W-1:0] lock_q,
    output logic [1:0]        mem_mode,
    output logic [1:0]        app_lock,
    output logic [1:0]        boot_lock
);
    lock_mode_e        mode;
    logic              allow, do_erase, do_write;
    logic [LOCK_W-1:0] new_val;
    rsp_state_e        state, state_nx;
    logic              path_unused;

    assign path_unused = req_path;   // both front ends obey the same rules

    lockbyte_decode u_decode (
        .lvl_bits (lock_q[LVL_LSB +: 2]),
        .mode     (mode)
    );

    lockbyte_policy u_policy (
        .mode     (mode),
        .kind     (req_kind),
        .cur      (lock_q),
        .data     (req_data),
        .allow    (allow),
        .do_erase (do_erase),
        .do_write (do_write),
        .new_val  (new_val)
    );

    lockbyte_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .erase  (req_valid && do_erase),
        .wr_en  (req_valid && do_write),
        .wr_val (new_val),
        .value  (lock_q)
    );

    always_comb begin
        if (!req_valid)    state_nx = RSP_IDLE;
        else if (do_erase) state_nx = RSP_ERASED;
        else if (allow)    state_nx = RSP_GRANT;
        else               state_nx = RSP_DENY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RSP_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        grant      = 1'b0;
        deny       = 1'b0;
        erase_done = 1'b0;
        unique case (state)
            RSP_IDLE:   ;
            RSP_GRANT:  grant = 1'b1;
            RSP_DENY:   deny  = 1'b1;
            RSP_ERASED: begin
                grant      = 1'b1;
                erase_done = 1'b1;
            end
        endcase
    end

    assign mem_mode  = mode;
    assign app_lock  = lock_q[APP_LSB +: 2];
    assign boot_lock = lock_q[BOOT_LSB +: 2];
endmodule

// File: rtl/lockbyte_ctrl_chk.sv
module lockbyte_ctrl_chk
    import lockbyte_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_kind,
    input logic              grant,
    input logic              deny,
    input logic              erase_done,
    input logic [LOCK_W-1:0] lock_q,
    input logic [1:0]        mem_mode
);
    assert_one_response_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && deny));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!grant && !deny));

    assert_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_kind == KIND_ERASE) |=> ((lock_q & ~$past(lock_q)) == '0));

    assert_erase_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_ERASE) |=> (lock_q == LOCK_BLANK && grant && erase_done));

    assert_sealed_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_LOCK_WR && mem_mode == 2'd2)
            |=> (lock_q[5:2] == $past(lock_q[5:2])));

    assert_sealed_prog_deny_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_MEM_PRG && mem_mode == 2'd2) |=> deny);

    assert_noprog_verify_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_MEM_VFY && mem_mode == 2'd1) |=> grant);
endmodule

bind lockbyte_ctrl lockbyte_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .grant      (grant),
    .deny       (deny),
    .erase_done (erase_done),
    .lock_q     (lock_q),
    .mem_mode   (mem_mode)
);

// File: tb/lockbyte_ctrl_bench.sv
module lockbyte_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_kind = 3'd0;
    logic       req_path = 1'b0;
    logic [7:0] req_data = 8'hFF;
    logic       grant, deny, erase_done;
    logic [7:0] lock_q;
    logic [1:0] mem_mode, app_lock, boot_lock;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lockbyte_ctrl u_lockbyte_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_path(req_path), .req_data(req_data), .grant(grant), .deny(deny),
        .erase_done(erase_done), .lock_q(lock_q), .mem_mode(mem_mode),
        .app_lock(app_lock), .boot_lock(boot_lock)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge; return at the next falling edge,
    // where the response pulse and updated byte are visible.
    task automatic send(input logic [2:0] kind, input logic [7:0] data, input logic path);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_data = data; req_path = path;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input bit g, input string req);
        check(grant == g && deny == !g, req, {grant, deny}, {g, !g});
    endtask

    task automatic t_reset();
        check(lock_q == 8'hFF, "R1", lock_q, 8'hFF);
        check(mem_mode == 2'd0, "R1", mem_mode, 0);
        check(!grant && !deny, "R1", {grant, deny}, 0);
    endtask

    task automatic t_open();
        send(3'd3, 8'h00, 0); expect_rsp(1, "R5 verify");
        send(3'd2, 8'h00, 0); expect_rsp(1, "R5 program");
        send(3'd1, 8'h00, 1); expect_rsp(1, "R5 fuse");
        check(lock_q == 8'hFF, "R5 byte", lock_q, 8'hFF);
        @(negedge clk);
        check(!grant && !deny, "R9 idle", {grant, deny}, 0);
    endtask

    task automatic t_program_and();
        send(3'd0, 8'hF7, 0); expect_rsp(1, "R3 write");
        check(lock_q == 8'hF7, "R3", lock_q, 8'hF7);
        send(3'd0, 8'hFF, 0);
        check(lock_q == 8'hF7, "R3 no set", lock_q, 8'hF7);
        send(3'd0, 8'hEF, 0);
        check(lock_q == 8'hE7, "R3 and", lock_q, 8'hE7);
        check(app_lock == 2'b01, "R2 app", app_lock, 2'b01);
        check(boot_lock == 2'b10, "R2 boot", boot_lock, 2'b10);
    endtask

    task automatic t_noprog();
        send(3'd0, 8'hFE, 0);
        check(lock_q == 8'hE6 && mem_mode == 2'd1, "R4 lvl 10", {lock_q, mem_mode}, {8'hE6, 2'd1});
        send(3'd1, 8'h00, 0); expect_rsp(0, "R6 fuse");
        send(3'd2, 8'h00, 0); expect_rsp(0, "R6 program serial");
        send(3'd2, 8'h00, 1); expect_rsp(0, "R10 program parallel");
        send(3'd3, 8'h00, 1); expect_rsp(1, "R6 verify");
        send(3'd0, 8'hFD, 0); expect_rsp(1, "R6 lock write");
        check(lock_q == 8'hE4 && mem_mode == 2'd2, "R4 lvl 00", {lock_q, mem_mode}, {8'hE4, 2'd2});
    endtask

    task automatic t_erase();
        send(3'd4, 8'h00, 0);
        check(grant && !deny && erase_done, "R8 pulse", {grant, deny, erase_done}, 3'b101);
        check(lock_q == 8'hFF, "R8 byte", lock_q, 8'hFF);
        @(negedge clk);
        check(!erase_done && !grant, "R9 single", {erase_done, grant}, 0);
    endtask

    task automatic t_sealed_undef();
        send(3'd0, 8'hFD, 0);
        check(mem_mode == 2'd2, "R4 lvl 01", mem_mode, 2'd2);
        send(3'd3, 8'h00, 0); expect_rsp(0, "R7 verify");
        send(3'd2, 8'h00, 0); expect_rsp(0, "R7 program");
        send(3'd1, 8'h00, 0); expect_rsp(0, "R7 fuse");
        send(3'd0, 8'h02, 0); expect_rsp(1, "R7 lock write");
        check(lock_q == 8'h3C, "R7 masked", lock_q, 8'h3C);
    endtask

    task automatic t_path_open();
        send(3'd2, 8'h00, 0); expect_rsp(1, "R10 serial open");
        send(3'd2, 8'h00, 1); expect_rsp(1, "R10 parallel open");
    endtask

    task automatic t_bad_kind();
        send(3'd0, 8'hBF, 0);
        for (int k = 5; k < 8; k++) begin
            send(3'(k), 8'h00, 0); expect_rsp(0, "R11 deny");
            check(lock_q == 8'hBF, "R11 byte", lock_q, 8'hBF);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_open();
        t_program_and();
        t_noprog();
        t_erase();
        t_sealed_undef();
        t_erase();
        t_path_open();
        t_bad_kind();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule